// File: doc/BRIEF.md
# Comma-Aligning Word Deserializer

This block is the receive side of a 20:1 serial link. It runs on a single clock and takes in recovered serial bits, each marked by a bit-valid strobe. A wrap control picks the source. One source is the external line. The other is an internal loopback path from the local transmitter. The block packs the chosen bits into 20-bit words, and the first bit received is placed in the lowest output bit.

A 7-bit window slides over the incoming stream and advances on every valid bit. When detection is enabled and the window holds the comma pattern, the word boundary is moved so that the comma's first bit becomes bit 0 of the next word. Any partly gathered word is thrown away. Each finished word appears on the output with a one-cycle word strobe and a flag that marks words carrying the comma. Clock recovery, equalization and line decoding are handled elsewhere.

Top module: `rx_comma_deser`

## Requirements
- R1: Each output word is 20 bits wide, and word_out[0] holds the earliest received bit of that word while word_out[19] holds the latest.
- R2: The comma is the arrival-order sequence 0,0,1,1,1,1,1, so word_out[6:0] equals 7'b1111100 when it is aligned. It is searched for at every bit position, not only at word boundaries.
- R3: With comma_en high, the bits that follow a detected comma are realigned, and that comma appears in word_out[6:0] of the next word.
- R4: comma_flag is high in the same cycle as word_stb exactly when comma_en is high and word_out[6:0] equals 7'b1111100. Otherwise it is low.
- R5: word_stb is high for one cycle, in the cycle after the clock edge that takes the 20th valid bit of a word. Cycles with the selected valid low add no bits.
- R6: While wrap_en is high, bits and valids come from wrap_bit/wrap_vld and the line inputs are ignored. While wrap_en is low, the line inputs are used.
- R7: With comma_en low, the word boundary is left unchanged even when a comma arrives misaligned, and comma_flag stays low.
- R8: A comma detection with comma_en high restarts the bit count so that the comma's first bit is word bit 0. No strobe is issued for the bits gathered before the comma.
- R9: After reset, word_stb, comma_flag and word_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_bit | input | 1 | Serial data from the external line |
| line_vld | input | 1 | Valid strobe for line_bit |
| wrap_bit | input | 1 | Serial data from the transmitter loopback |
| wrap_vld | input | 1 | Valid strobe for wrap_bit |
| wrap_en | input | 1 | Selects the loopback source when high |
| comma_en | input | 1 | Enables comma detection and realignment |
| word_out | output | 20 | Assembled word, bit 0 earliest |
| word_stb | output | 1 | One-cycle marker of a new word |
| comma_flag | output | 1 | Word carries the aligned comma |

## Verification
The assertions assume that comma_en is steady while a word is being received. This keeps the flag tied to the enable of the cycle that produced it. The checks also assume that the selected source does not change in the middle of a word. The stimulus changes comma_en and wrap_en only after the last word has drained and the input has been idle for several cycles. Between commas, the payload is built from alternating bit runs so that no unintended comma appears at any offset, including across word seams.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int unsigned WORD_W  = 20;
  localparam int unsigned COMMA_W = 7;
  // bit 0 is the earliest bit: arrival 0,0,1,1,1,1,1
  localparam logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100;

  function automatic logic comma_match(input logic [COMMA_W-1:0] win);
    return win == COMMA_PAT;
  endfunction

  // bit position following the current one; a restart lands just past the comma
  function automatic int unsigned next_pos(input int unsigned pos,
                                           input logic restart,
                                           input int unsigned wlen,
                                           input int unsigned clen);
    if (restart)           return clen;
    else if (pos == wlen-1) return 0;
    else                    return pos + 1;
  endfunction
endpackage

// File: rtl/rx_src_sel.sv
module rx_src_sel (
  input  logic line_bit,
  input  logic line_vld,
  input  logic wrap_bit,
  input  logic wrap_vld,
  input  logic wrap_en,
  output logic sel_bit,
  output logic sel_vld
);
  always_comb begin
    if (wrap_en) begin
      sel_bit = wrap_bit;
      sel_vld = wrap_vld;
    end else begin
      sel_bit = line_bit;
      sel_vld = line_vld;
    end
  end
endmodule

// File: rtl/rx_comma_scan.sv
module rx_comma_scan #(
  parameter int unsigned CW = rxd_pkg::COMMA_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  output logic hit
);
  logic [CW-1:0] hist;
  logic [CW-1:0] hist_nx;

  // newest bit enters at the top, oldest sits at bit 0
  assign hist_nx = {bit_in, hist[CW-1:1]};
  assign hit     = bit_vld && rxd_pkg::comma_match(hist_nx);

  // reset to ones so no comma can be formed from pre-reset filler
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist <= '1;
    else if (bit_vld) hist <= hist_nx;
  end
endmodule

// File: rtl/rx_word_asm.sv
module rx_word_asm #(
  parameter int unsigned WW = rxd_pkg::WORD_W,
  parameter int unsigned CW = rxd_pkg::COMMA_W,
  localparam int unsigned PW = $clog2(WW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  input  logic          bit_vld,
  input  logic          restart,
  input  logic          comma_en,
  output logic [WW-1:0] word_out,
  output logic          word_stb,
  output logic          comma_flag,
  output logic          word_done
);
  logic [WW-1:0] sr;
  logic [WW-1:0] sr_nx;
  logic [PW-1:0] pos;

  assign sr_nx     = {bit_in, sr[WW-1:1]};
  assign word_done = bit_vld && !restart && (pos == PW'(WW-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      pos <= '0;
    end else if (bit_vld) begin
      sr  <= sr_nx;
      pos <= PW'(rxd_pkg::next_pos(int'(pos), restart, WW, CW));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_stb   <= 1'b0;
      comma_flag <= 1'b0;
    end else begin
      word_stb <= word_done;
      if (word_done) begin
        word_out   <= sr_nx;
        comma_flag <= comma_en && rxd_pkg::comma_match(sr_nx[CW-1:0]);
      end else begin
        comma_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_comma_deser.sv
module rx_comma_deser #(
  parameter int unsigned WORD_W  = rxd_pkg::WORD_W,
  parameter int unsigned COMMA_W = rxd_pkg::COMMA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_bit,
  input  logic              line_vld,
  input  logic              wrap_bit,
  input  logic              wrap_vld,
  input  logic              wrap_en,
  input  logic              comma_en,
  output logic [WORD_W-1:0] word_out,
  output logic              word_stb,
  output logic              comma_flag
);
  logic sel_bit;
  logic sel_vld;
  logic comma_hit;
  logic restart;
  logic word_done;

  rx_src_sel u_src (
    .line_bit (line_bit),
    .line_vld (line_vld),
    .wrap_bit (wrap_bit),
    .wrap_vld (wrap_vld),
    .wrap_en  (wrap_en),
    .sel_bit  (sel_bit),
    .sel_vld  (sel_vld)
  );

  rx_comma_scan #(.CW(COMMA_W)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (sel_bit),
    .bit_vld (sel_vld),
    .hit     (comma_hit)
  );

  assign restart = comma_hit && comma_en;

  rx_word_asm #(.WW(WORD_W), .CW(COMMA_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_in     (sel_bit),
    .bit_vld    (sel_vld),
    .restart    (restart),
    .comma_en   (comma_en),
    .word_out   (word_out),
    .word_stb   (word_stb),
    .comma_flag (comma_flag),
    .word_done  (word_done)
  );
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int unsigned WORD_W  = rxd_pkg::WORD_W,
  parameter int unsigned COMMA_W = rxd_pkg::COMMA_W,
  localparam int unsigned BW = $clog2(WORD_W) + 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               comma_en,
  input logic               sel_vld,
  input logic               restart,
  input logic [COMMA_W-1:0] word_lo,
  input logic               word_stb,
  input logic               comma_flag
);
  logic [BW-1:0] bits_since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   bits_since <= '0;
    else if (word_stb)            bits_since <= BW'(sel_vld);
    else if (sel_vld && !(&bits_since)) bits_since <= bits_since + 1'b1;
  end

  AST_FLAG_CONTENT: assert property (@(posedge clk) disable iff (!rst_n)
    comma_flag |-> (word_stb && word_lo == rxd_pkg::COMMA_PAT)); // R4
  AST_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    comma_flag |-> $past(comma_en)); // R7
  AST_STB_PACING: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> (bits_since >= BW'(WORD_W))); // R5
  AST_RESTART_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !word_stb); // R8
endmodule

bind rx_comma_deser rxd_checker #(.WORD_W(WORD_W), .COMMA_W(COMMA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .comma_en   (comma_en),
  .sel_vld    (sel_vld),
  .restart    (restart),
  .word_lo    (word_out[COMMA_W-1:0]),
  .word_stb   (word_stb),
  .comma_flag (comma_flag)
);

// File: tb/sim_rx_comma_deser.sv
`timescale 1ns/1ps
module sim_rx_comma_deser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_bit = 1'b0, line_vld = 1'b0;
  logic wrap_bit = 1'b0, wrap_vld = 1'b0;
  logic wrap_en = 1'b0, comma_en = 1'b0;
  logic [19:0] word_out;
  logic word_stb, comma_flag;

  int n_chk = 0;
  int n_fail = 0;
  logic use_wrap = 1'b0;
  logic gappy = 1'b0;

  logic [19:0] cap_w [0:63];
  logic        cap_f [0:63];
  int ncap = 0;

  localparam logic [19:0] C1 = {13'h0AAA, 7'b1111100};
  localparam logic [19:0] C2 = {13'h1555, 7'b1111100};
  localparam logic [19:0] DA = 20'hAAAAA;
  localparam logic [19:0] DB = 20'h55555;

  always #10 clk = ~clk;

  rx_comma_deser u0 (
    .clk(clk), .rst_n(rst_n),
    .line_bit(line_bit), .line_vld(line_vld),
    .wrap_bit(wrap_bit), .wrap_vld(wrap_vld),
    .wrap_en(wrap_en), .comma_en(comma_en),
    .word_out(word_out), .word_stb(word_stb), .comma_flag(comma_flag)
  );

  always @(negedge clk) begin
    if (rst_n && word_stb && ncap < 64) begin
      cap_w[ncap] = word_out;
      cap_f[ncap] = comma_flag;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_vld = 1'b0; wrap_vld = 1'b0;
      line_bit = 1'b1; wrap_bit = 1'b0;
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    if (use_wrap) begin
      wrap_bit = b; wrap_vld = 1'b1;
      line_bit = 1'b1; line_vld = 1'b1;   // junk on the ignored source
    end else begin
      line_bit = b; line_vld = 1'b1;
      wrap_bit = 1'b0; wrap_vld = 1'b0;
    end
    if (gappy) idle(1);
  endtask

  task automatic send_stream(input logic [127:0] s, input int n);
    for (int i = 0; i < n; i++) send_bit(s[i]);
    idle(4);
  endtask

  task automatic expect_words(input string req, input int n,
                              input logic [19:0] w0, input logic f0,
                              input logic [19:0] w1, input logic f1,
                              input logic [19:0] w2, input logic f2,
                              input logic [19:0] w3, input logic f3);
    logic [19:0] ew [4];
    logic        ef [4];
    ew = '{w0, w1, w2, w3};
    ef = '{f0, f1, f2, f3};
    chk(ncap == n, {req, " word count"}, 32'(ncap), 32'(n));
    for (int i = 0; i < n && i < ncap; i++) begin
      chk(cap_w[i] == ew[i], {req, " word"}, 32'(cap_w[i]), 32'(ew[i]));
      chk(cap_f[i] == ef[i], {req, " flag"}, 32'(cap_f[i]), 32'(ef[i]));
    end
    ncap = 0;
  endtask

  // R9: reset values
  task automatic t_reset();
    chk(word_stb == 1'b0, "R9 stb", 32'(word_stb), 0);
    chk(comma_flag == 1'b0, "R9 flag", 32'(comma_flag), 0);
    chk(word_out == 20'h0, "R9 word", 32'(word_out), 0);
  endtask

  // R1 R5 R7: detection off, plain words pass bit for bit
  task automatic t_plain();
    comma_en = 1'b0;
    send_stream({C1, 20'h12345, 20'hABCDE}, 60);
    expect_words("R1 R7", 3, 20'hABCDE, 0, 20'h12345, 0, C1, 0, 0, 0);
  endtask

  // R2 R3 R4 R8: comma at a 9-bit offset relocks the boundary
  task automatic t_align();
    comma_en = 1'b1;
    idle(2);
    send_stream({DA, C2, DA, C1, 9'h155}, 89);
    expect_words("R3 R4", 4, C1, 1, DA, 0, C2, 1, DA, 0);
  endtask

  // R8: mid-stream relock drops the partial word
  task automatic t_relock();
    send_stream({DB, C2, 5'h15}, 45);
    expect_words("R8 R2", 2, C2, 1, DB, 0, 0, 0, 0, 0);
  endtask

  // R6 R5: loopback source with gaps in valid
  task automatic t_wrap();
    wrap_en = 1'b1; use_wrap = 1'b1; gappy = 1'b1;
    idle(2);
    send_stream({DA, C1}, 40);
    expect_words("R6 R5", 2, C1, 1, DA, 0, 0, 0, 0, 0);
    wrap_en = 1'b0; use_wrap = 1'b0; gappy = 1'b0;
    idle(2);
  endtask

  // R7: misaligned comma with detection off keeps the old boundary
  task automatic t_off_misaligned();
    comma_en = 1'b0;
    idle(2);
    send_stream({16'h5555, C1, 4'b0101}, 40);
    expect_words("R7", 2, {C1[15:0], 4'b0101}, 0, {16'h5555, C1[19:16]}, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_plain();
    t_align();
    t_relock();
    t_wrap();
    t_off_misaligned();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule